// File: doc/BRIEF.md
# Memory Read Bus Cycle Controller

This block sits between a processor core and a slow parallel memory bus and carries out one read at a time. When the core raises a request with an address while the block is idle, the block puts that address on the bus for one setup cycle and then pulls the active-low read strobe down. The strobe stays low for the strobe assertion cycle plus a fixed number of memory wait cycles. On the clock edge where the strobe is released, the block captures the bus data word.

In the cycle after that edge, the captured word is handed back to the core with a single-cycle valid pulse. The busy output covers the whole transaction, and it drops right after the valid pulse. A request that arrives while busy is high is discarded. The core has to hold off until busy is low and then issue the request again. A read therefore takes several clock cycles, because the memory is much slower than the core.

Top module: `rdbus_ctrl`

## Requirements
- R1: After a synchronous reset, `bus_rd_n_o` is 1, `busy_o` is 0 and `rvalid_o` is 0.
- R2: A request sampled with `req_i`=1 while `busy_o`=0 is accepted. In the next cycle `busy_o` is 1, `bus_addr_o` equals the requested address and `bus_rd_n_o` is still 1, which gives one address setup cycle.
- R3: After the setup cycle, `bus_rd_n_o` is 0 for exactly WAIT_CYC+1 consecutive cycles. With the default WAIT_CYC=1 this is 2 cycles.
- R4: `bus_addr_o` does not change on any cycle while `busy_o` stays 1.
- R5: `rdata_o` carries the value that `bus_data_i` held in the last cycle the strobe was low. This is captured on the edge where `bus_rd_n_o` returns to 1, and data driven in earlier strobe-low cycles is not used.
- R6: `rvalid_o` is 1 for exactly one cycle per accepted request. That cycle immediately follows the last strobe-low cycle, and `bus_rd_n_o` is 1 during it.
- R7: `busy_o` is 0 in the cycle after the valid pulse, so a transaction keeps `busy_o` high for WAIT_CYC+3 cycles. A request presented in the first idle cycle is accepted.
- R8: A request presented while `busy_o`=1 has no effect. It produces no extra valid pulse, does not change `bus_addr_o`, and starts no transaction after the current one ends.
- R9: `bus_rd_n_o` is 1 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Read request from the core |
| req_addr_i | input | ADDR_W | Address of the requested word |
| busy_o | output | 1 | A transaction is in progress |
| rdata_o | output | DATA_W | Word returned to the core |
| rvalid_o | output | 1 | One-cycle pulse: `rdata_o` holds the result |
| bus_addr_o | output | ADDR_W | Memory address bus |
| bus_rd_n_o | output | 1 | Active-low read strobe |
| bus_data_i | input | DATA_W | Memory data bus |

## Verification
The assertions assume that the memory drives a known value on `bus_data_i` in every cycle. They also assume that the core drives `req_i` and `req_addr_i` only on the clock it intends, with no reset asserted in the middle of a transaction. The bench's memory model drives a word that depends on the address in the final strobe-low cycle and a decoy word in every other cycle, so capturing on the wrong edge produces a visible mismatch. The core model drives requests only between clock edges. It issues them back to back the moment busy drops, and on purpose it pulses extra requests with a different address while busy is high.

// File: rtl/rdbus_pkg.sv
package rdbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_RETURN = 2'd3
  } rd_state_e;

  // cycles the read strobe is held low: assertion cycle plus memory waits
  function automatic int unsigned strobe_len(input int unsigned waits);
    return waits + 1;
  endfunction

  // cycles busy stays high: setup + strobe + return
  function automatic int unsigned busy_len(input int unsigned waits);
    return strobe_len(waits) + 2;
  endfunction

endpackage

// File: rtl/rdbus_fsm.sv
module rdbus_fsm
  import rdbus_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  output rd_state_e state,
  output logic      accept,
  output logic      capture
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CYC);

  rd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept  = (state_q == ST_IDLE) && req;
  assign capture = (state_q == ST_STROBE) && (cnt_q == LAST_CNT);
  assign state   = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = ST_STROBE;
        cnt_d   = '0;
      end
      ST_STROBE: begin
        if (capture) state_d = ST_RETURN;
        else         cnt_d   = cnt_q + 1'b1;
      end
      ST_RETURN: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/rdbus_datapath.sv
module rdbus_datapath #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept)  addr_q <= req_addr;
      if (capture) data_q <= bus_data;
    end
  end

endmodule

// File: rtl/rdbus_ctrl.sv
module rdbus_ctrl
  import rdbus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_n_o,
  input  logic [DATA_W-1:0] bus_data_i
);

  rd_state_e state_w;
  logic      accept_w;
  logic      capture_w;

  rdbus_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req_i),
    .state   (state_w),
    .accept  (accept_w),
    .capture (capture_w)
  );

  rdbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept_w),
    .capture  (capture_w),
    .req_addr (req_addr_i),
    .bus_data (bus_data_i),
    .addr_q   (bus_addr_o),
    .data_q   (rdata_o)
  );

  assign busy_o     = (state_w != ST_IDLE);
  assign rvalid_o   = (state_w == ST_RETURN);
  assign bus_rd_n_o = (state_w != ST_STROBE);

endmodule

// File: rtl/rdbus_checker.sv
module rdbus_checker
  import rdbus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WAIT_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_rd_n_o,
  input logic [DATA_W-1:0] bus_data_i,
  input logic              accept,
  input logic              capture
);
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst)             low_run <= 0;
    else if (!bus_rd_n_o) low_run <= low_run + 1;
    else                 low_run <= 0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (bus_rd_n_o && !busy_o && !rvalid_o)); // R1
  AST_ACCEPT_SETUP: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy_o) |=> (busy_o && bus_rd_n_o && bus_addr_o == $past(req_addr_i))); // R2
  AST_ACCEPT_EVENT: assert property (@(posedge clk) disable iff (rst)
    accept |-> !busy_o); // R8
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd_n_o) |-> (low_run == strobe_len(WAIT_CYC))); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o)); // R4
  AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (rst)
    capture |-> (!bus_rd_n_o ##1 bus_rd_n_o)); // R5
  AST_DATA_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> (rdata_o == $past(bus_data_i))); // R5
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |=> !rvalid_o); // R6
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> (bus_rd_n_o && !$past(bus_rd_n_o))); // R6
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |=> !busy_o); // R7
  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> bus_rd_n_o); // R9

endmodule

bind rdbus_ctrl rdbus_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .req_addr_i (req_addr_i),
  .busy_o     (busy_o),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .bus_addr_o (bus_addr_o),
  .bus_rd_n_o (bus_rd_n_o),
  .bus_data_i (bus_data_i),
  .accept     (accept_w),
  .capture    (capture_w)
);

// File: tb/sim_rdbus_ctrl.sv
`timescale 1ns/1ps
module sim_rdbus_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WAITS = 1;
  localparam int LOW_EXP  = WAITS + 1;   // strobe low cycles
  localparam int BUSY_EXP = 1 + LOW_EXP + 1; // setup + strobe + return

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, rvalid, rd_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int seen   = 0;
  bit done_flag = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  rdbus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(WAITS)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .req_addr_i(req_addr),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid),
    .bus_addr_o(bus_addr), .bus_rd_n_o(rd_n), .bus_data_i(bus_data)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[7:0], a[31:24] ^ 8'h5A, a[15:8], a[23:16]} + 32'h0137_9BDF;
  endfunction

  // memory model: real word only in the final low cycle, decoy otherwise
  int mem_low = 0;
  always @(posedge clk) begin
    if (rst || rd_n) mem_low <= 0;
    else             mem_low <= mem_low + 1;
  end
  always_comb begin
    if (!rd_n && mem_low == WAITS) bus_data = mem_word(bus_addr);
    else                           bus_data = ~mem_word(bus_addr) ^ 32'hC0DE_0000;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  // driver: waits for idle, issues one request, pushes the expected word
  task automatic do_read(input logic [AW-1:0] a);
    while (busy) @(negedge clk);
    req = 1'b1;
    req_addr = a;
    exp_q.push_back(mem_word(a));
    issued++;
    @(negedge clk);
    req = 1'b0;
    req_addr = ~a;
    chk(busy == 1'b1, "R2 busy", 32'(busy), 1);
    chk(bus_addr == a, "R2 addr", bus_addr, a);
    chk(rd_n == 1'b1, "R2 setup strobe", 32'(rd_n), 1);
  endtask

  // monitor: scoreboard plus timing of strobe and busy
  int low_run = 0, busy_run = 0;
  bit prev_valid = 0, prev_busy = 0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!rd_n) low_run++;
      else begin
        if (low_run != 0) chk(low_run == LOW_EXP, "R3 strobe length", low_run, LOW_EXP);
        low_run = 0;
      end
      if (busy) busy_run++;
      else begin
        if (busy_run != 0) chk(busy_run == BUSY_EXP, "R7 busy length", busy_run, BUSY_EXP);
        busy_run = 0;
        if (!rd_n) chk(0, "R9 strobe while idle", 32'(rd_n), 1);
      end
      if (busy && prev_busy && bus_addr != prev_addr)
        chk(0, "R4 address moved", bus_addr, prev_addr);
      if (prev_valid) begin
        chk(!rvalid, "R6 valid width", 32'(rvalid), 0);
        chk(!busy, "R7 busy after valid", 32'(busy), 0);
      end
      if (rvalid) begin
        seen++;
        chk(rd_n == 1'b1, "R6 strobe high at valid", 32'(rd_n), 1);
        if (exp_q.size() == 0) chk(0, "R8 unexpected valid", rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R5 read data", rdata, e);
        end
      end
      prev_valid = rvalid;
      prev_busy  = busy;
      prev_addr  = bus_addr;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rd_n == 1'b1, "R1 strobe", 32'(rd_n), 1);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(rvalid == 1'b0, "R1 valid", 32'(rvalid), 0);
    @(negedge clk);
    do_read(32'h0000_0000);
    do_read(32'hFFFF_FFFF);
    do_read(32'h1234_5678);
    for (int i = 0; i < 6; i++) do_read(32'h8000_0000 >> i ^ (i * 32'h0101_0101));
    // R8: extra requests while busy must be dropped
    do_read(32'hA5A5_0F0F);
    req = 1'b1; req_addr = 32'h0BAD_0BAD;
    @(negedge clk);
    req = 1'b1; req_addr = 32'h0BAD_1BAD;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 no new transaction", 32'(busy), 0);
    chk(bus_addr == 32'hA5A5_0F0F, "R8 address kept", bus_addr, 32'hA5A5_0F0F);
    // R7: back-to-back reads accepted in the first idle cycle
    do_read(32'h00C0_FFEE);
    do_read(32'h7FFF_FFFE);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(seen == issued, "R8 valid count", seen, issued);
    chk(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    // R1: reset again after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(rd_n && !busy && !rvalid, "R1 reset after use", {rd_n, busy, rvalid}, 3'b100);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule